// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the general-purpose register storage of a processor core that runs in seven execution modes. It exposes sixteen 32-bit architectural registers. Some architectural numbers select a different physical entry depending on the current mode. The fast-interrupt mode keeps private copies of registers 8 through 14. The other four exception modes keep private copies of only registers 13 and 14. User and system modes share one set. Registers 0 through 7 and register 15 are common to every mode.

Two combinational read ports and one write port are addressed by a 4-bit register number and share the 5-bit mode input. The exception controller has a separate override port. It writes register 14 of a chosen target mode, so the return address can be stored before that mode becomes current. Each of the five exception modes also owns one saved-status word, which is read and written in the current mode.

Every access completes in the cycle it is presented, so the pins are plain register-file signals with no valid/ready handshake. No back-pressure exists: a write that is enabled at a rising edge always lands, and a read port always shows its data.

Top module: `mode_banked_regfile`

## Requirements
- R1: While reset is asserted (active low) every general entry and every saved-status word clears to zero. After release, any read returns zero until that entry is written.
- R2: The mode input is decoded as follows: user 5'h10, fast interrupt 5'h11, interrupt 5'h12, supervisor 5'h13, abort 5'h17, undefined 5'h1B, system 5'h1F. Any other value selects the user register set and has no saved-status word.
- R3: Registers 0–7 and register 15 are a single physical set that reads and writes identically in every mode.
- R4: In fast-interrupt mode, registers 8–14 select seven private entries, distinct from every other mode's entries.
- R5: In interrupt, supervisor, abort and undefined modes, registers 13 and 14 select a private pair per mode, while registers 8–12 reach the user entries.
- R6: System mode reads and writes exactly the user-mode entries.
- R7: Both read ports are combinational and independent. When the write port (or the override port) targets the physical entry a read port selects in the same cycle, the read returns the incoming data.
- R8: The override port writes register 14 of its own target mode regardless of the current mode. A user, system or unknown target writes the user register 14. If the override and the write port hit the same entry in one cycle, the override value is stored and forwarded.
- R9: Each of the five exception modes has its own saved-status word. The read port shows the word of the current mode, and a write in the same cycle is forwarded to that read.
- R10: In user, system or unknown modes the saved-status read returns zero, and a saved-status write leaves every stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 5 | Current execution mode |
| rd_a_idx | input | 4 | Register number for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Register number for read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 4 | Register number for the write port |
| wr_data | input | 32 | Write port data |
| lr_ovr_en | input | 1 | Override write enable for a target mode's register 14 |
| lr_ovr_mode | input | 5 | Target mode of the override write |
| lr_ovr_data | input | 32 | Override write data |
| sps_rd_data | output | 32 | Saved-status word of the current mode |
| sps_wr_en | input | 1 | Saved-status write enable |
| sps_wr_data | input | 32 | Saved-status write data |

## Verification
Several properties are checked on every cycle. The index mapper keeps the common registers on their own index and never produces a physical index past the last entry. The forwarding paths return incoming data on a same-entry hit. An override wins a collision with the write port, a saved-status write lands in the current mode's slot, and user or system mode reads zero status. Only the bench's scenarios can show that the banking is correct across modes: that each private copy is distinct from the others, that the shared entries really are shared, that unknown encodings fall back to the user set, and that ignored status writes leave every stored word untouched.

// File: rtl/rbrf_pkg.sv
package rbrf_pkg;
  localparam int AW       = 4;
  localparam int MW       = 5;
  localparam int ARCH_N   = 1 << AW;
  localparam int FIQ_LO   = 8;
  localparam int SP_IDX   = 13;
  localparam int LR_IDX   = 14;
  localparam int PC_IDX   = 15;
  localparam int FIQ_N    = PC_IDX - FIQ_LO;
  localparam int PAIR_N   = 4;
  localparam int FIQ_BASE = ARCH_N;
  localparam int PAIR_BASE = FIQ_BASE + FIQ_N;
  localparam int NPHYS    = PAIR_BASE + 2 * PAIR_N;
  localparam int PW       = $clog2(NPHYS);
  localparam int NEXC     = 1 + PAIR_N;

  localparam logic [MW-1:0] MD_USR = 5'h10;
  localparam logic [MW-1:0] MD_FIQ = 5'h11;
  localparam logic [MW-1:0] MD_IRQ = 5'h12;
  localparam logic [MW-1:0] MD_SVC = 5'h13;
  localparam logic [MW-1:0] MD_ABT = 5'h17;
  localparam logic [MW-1:0] MD_UND = 5'h1B;
  localparam logic [MW-1:0] MD_SYS = 5'h1F;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  // System mode and every unrecognised code fall back to the user set.
  function automatic bank_e decode_bank(input logic [MW-1:0] m);
    bank_e b;
    case (m)
      MD_FIQ:  b = BK_FIQ;
      MD_IRQ:  b = BK_IRQ;
      MD_SVC:  b = BK_SVC;
      MD_ABT:  b = BK_ABT;
      MD_UND:  b = BK_UND;
      default: b = BK_USR;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/rbrf_map.sv
module rbrf_map
  import rbrf_pkg::*;
(
  input  logic [MW-1:0] mode,
  input  logic [AW-1:0] arch,
  output logic [PW-1:0] phys
);
  bank_e      bank;
  logic [2:0] bk_raw;
  logic [1:0] pair_k;
  logic       in_fiq_range;
  logic       in_pair_range;

  always_comb begin
    bank          = decode_bank(mode);
    bk_raw        = bank;
    pair_k        = 2'(bk_raw - 3'(BK_IRQ));
    in_fiq_range  = (arch >= AW'(FIQ_LO)) && (arch != AW'(PC_IDX));
    in_pair_range = (arch == AW'(SP_IDX)) || (arch == AW'(LR_IDX));
    phys          = PW'(arch);
    if (bank == BK_FIQ && in_fiq_range) begin
      phys = PW'(FIQ_BASE + int'(arch) - FIQ_LO);
    end else if (bank != BK_USR && bank != BK_FIQ && in_pair_range) begin
      phys = PW'(PAIR_BASE + 2 * int'(pair_k) + ((arch == AW'(LR_IDX)) ? 1 : 0));
    end
  end

  always_comb begin
    // R3
    if (arch < AW'(FIQ_LO) || arch == AW'(PC_IDX)) begin
      shared_low_chk: assert (phys == PW'(arch));
    end
    // R4
    phys_range_chk: assert (int'(phys) < NPHYS);
  end
endmodule

// File: rtl/rbrf_store.sv
module rbrf_store
  import rbrf_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NREAD = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [PW-1:0]       wr_addr,
  input  logic [DW-1:0]       wr_data,
  input  logic                ovr_en,
  input  logic [PW-1:0]       ovr_addr,
  input  logic [DW-1:0]       ovr_data,
  input  logic [NREAD-1:0][PW-1:0] rd_addr,
  output logic [NREAD-1:0][DW-1:0] rd_data
);
  logic [DW-1:0] mem [NPHYS];

  for (genvar e = 0; e < NPHYS; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mem[e] <= '0;
      end else if (ovr_en && ovr_addr == PW'(e)) begin
        mem[e] <= ovr_data;
      end else if (wr_en && wr_addr == PW'(e)) begin
        mem[e] <= wr_data;
      end
    end
  end

  for (genvar p = 0; p < NREAD; p++) begin : g_rd
    always_comb begin
      if (ovr_en && ovr_addr == rd_addr[p]) begin
        rd_data[p] = ovr_data;
      end else if (wr_en && wr_addr == rd_addr[p]) begin
        rd_data[p] = wr_data;
      end else if (int'(rd_addr[p]) < NPHYS) begin
        rd_data[p] = mem[rd_addr[p]];
      end else begin
        rd_data[p] = '0;
      end
    end
  end

  // R8
  ovr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_en && wr_en && ovr_addr == wr_addr) |=> mem[$past(ovr_addr)] == $past(ovr_data));

  // R7
  wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(ovr_en && ovr_addr == wr_addr)) |=> mem[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/rbrf_status.sv
module rbrf_status
  import rbrf_pkg::*;
#(
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] mode,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_data,
  output logic [SW-1:0] rd_data
);
  bank_e         bank;
  logic          is_exc;
  logic [2:0]    slot;
  logic [SW-1:0] sav [NEXC];

  always_comb begin
    bank   = decode_bank(mode);
    is_exc = (bank != BK_USR);
    slot   = 3'(bank) - 3'd1;
  end

  for (genvar s = 0; s < NEXC; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sav[s] <= '0;
      end else if (wr_en && is_exc && slot == 3'(s)) begin
        sav[s] <= wr_data;
      end
    end
  end

  always_comb begin
    if (!is_exc) begin
      rd_data = '0;
    end else if (wr_en) begin
      rd_data = wr_data;
    end else begin
      rd_data = sav[slot];
    end
  end

  // R10
  priv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_exc |-> rd_data == '0);

  // R9
  sps_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_exc) |=> sav[$past(slot)] == $past(wr_data));
endmodule

// File: rtl/mode_banked_regfile.sv
module mode_banked_regfile
  import rbrf_pkg::*;
#(
  parameter int DW = 32,
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] mode,
  input  logic [AW-1:0] rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  input  logic [AW-1:0] rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          lr_ovr_en,
  input  logic [MW-1:0] lr_ovr_mode,
  input  logic [DW-1:0] lr_ovr_data,
  output logic [SW-1:0] sps_rd_data,
  input  logic          sps_wr_en,
  input  logic [SW-1:0] sps_wr_data
);
  localparam int NREAD = 2;

  logic [NREAD-1:0][AW-1:0] rd_idx;
  logic [NREAD-1:0][PW-1:0] rd_phys;
  logic [NREAD-1:0][DW-1:0] rd_val;
  logic [PW-1:0]            wr_phys;
  logic [PW-1:0]            ovr_phys;

  assign rd_idx[0] = rd_a_idx;
  assign rd_idx[1] = rd_b_idx;

  for (genvar p = 0; p < NREAD; p++) begin : g_rmap
    rbrf_map u_map (
      .mode (mode),
      .arch (rd_idx[p]),
      .phys (rd_phys[p])
    );
  end

  rbrf_map u_wmap (
    .mode (mode),
    .arch (wr_idx),
    .phys (wr_phys)
  );

  rbrf_map u_omap (
    .mode (lr_ovr_mode),
    .arch (AW'(LR_IDX)),
    .phys (ovr_phys)
  );

  rbrf_store #(.DW(DW), .NREAD(NREAD)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_phys),
    .wr_data  (wr_data),
    .ovr_en   (lr_ovr_en),
    .ovr_addr (ovr_phys),
    .ovr_data (lr_ovr_data),
    .rd_addr  (rd_phys),
    .rd_data  (rd_val)
  );

  rbrf_status #(.SW(SW)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .wr_en   (sps_wr_en),
    .wr_data (sps_wr_data),
    .rd_data (sps_rd_data)
  );

  assign rd_a_data = rd_val[0];
  assign rd_b_data = rd_val[1];

  // R7
  fwd_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_phys == rd_phys[0] && !(lr_ovr_en && ovr_phys == rd_phys[0]))
      |-> rd_a_data == wr_data);

  // R7
  fwd_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_phys == rd_phys[1] && !(lr_ovr_en && ovr_phys == rd_phys[1]))
      |-> rd_b_data == wr_data);

  // R8
  ovr_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_ovr_en && ovr_phys == rd_phys[0]) |-> rd_a_data == lr_ovr_data);
endmodule

// File: tb/tb_mode_banked_regfile.sv
module tb_mode_banked_regfile;
  localparam logic [4:0] M_USR = 5'h10, M_FIQ = 5'h11, M_IRQ = 5'h12, M_SVC = 5'h13;
  localparam logic [4:0] M_ABT = 5'h17, M_UND = 5'h1B, M_SYS = 5'h1F;
  localparam int NV = 30;

  // {is_read, req, mode, idx, value}
  localparam logic [45:0] TBL [NV] = '{
    {1'b0, 4'd0, M_USR, 4'd8,  32'h0108},
    {1'b0, 4'd0, M_USR, 4'd13, 32'h010D},
    {1'b0, 4'd0, M_USR, 4'd14, 32'h010E},
    {1'b0, 4'd0, M_FIQ, 4'd8,  32'h0208},
    {1'b0, 4'd0, M_FIQ, 4'd13, 32'h020D},
    {1'b0, 4'd0, M_IRQ, 4'd13, 32'h030D},
    {1'b0, 4'd0, M_IRQ, 4'd14, 32'h030E},
    {1'b0, 4'd0, M_SVC, 4'd13, 32'h040D},
    {1'b0, 4'd0, M_ABT, 4'd14, 32'h050E},
    {1'b0, 4'd0, M_UND, 4'd13, 32'h060D},
    {1'b0, 4'd0, M_SYS, 4'd3,  32'h0703},
    {1'b0, 4'd0, M_IRQ, 4'd15, 32'h080F},
    // R4 fast-interrupt private copies
    {1'b1, 4'd4, M_FIQ, 4'd8,  32'h0208},
    {1'b1, 4'd4, M_FIQ, 4'd13, 32'h020D},
    {1'b1, 4'd4, M_FIQ, 4'd9,  32'h0000},
    // R5 private pairs, shared 8..12
    {1'b1, 4'd5, M_IRQ, 4'd8,  32'h0108},
    {1'b1, 4'd5, M_IRQ, 4'd13, 32'h030D},
    {1'b1, 4'd5, M_IRQ, 4'd14, 32'h030E},
    {1'b1, 4'd5, M_SVC, 4'd13, 32'h040D},
    {1'b1, 4'd5, M_SVC, 4'd14, 32'h0000},
    {1'b1, 4'd5, M_ABT, 4'd14, 32'h050E},
    {1'b1, 4'd5, M_UND, 4'd13, 32'h060D},
    {1'b1, 4'd5, M_UND, 4'd14, 32'h0000},
    // R6 system equals user
    {1'b1, 4'd6, M_SYS, 4'd13, 32'h010D},
    {1'b1, 4'd6, M_SYS, 4'd14, 32'h010E},
    {1'b1, 4'd6, M_USR, 4'd3,  32'h0703},
    // R3 common registers
    {1'b1, 4'd3, M_FIQ, 4'd3,  32'h0703},
    {1'b1, 4'd3, M_USR, 4'd15, 32'h080F},
    // R2 unknown codes use the user set
    {1'b1, 4'd2, 5'h00, 4'd13, 32'h010D},
    {1'b1, 4'd2, 5'h1A, 4'd8,  32'h0108}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  mode = M_USR;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0, lr_ovr_en = 1'b0, sps_wr_en = 1'b0;
  logic [4:0]  lr_ovr_mode = M_USR;
  logic [31:0] lr_ovr_data = '0, sps_rd_data, sps_wr_data = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mode_banked_regfile dut (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .lr_ovr_en(lr_ovr_en), .lr_ovr_mode(lr_ovr_mode), .lr_ovr_data(lr_ovr_data),
    .sps_rd_data(sps_rd_data), .sps_wr_en(sps_wr_en), .sps_wr_data(sps_wr_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en = 1'b0; lr_ovr_en = 1'b0; sps_wr_en = 1'b0;
  endtask

  task automatic rd_at(input logic [4:0] m, input logic [3:0] idx);
    idle();
    mode = m; rd_a_idx = idx; rd_b_idx = idx;
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    idle();
    rst_n = 1'b1;

    // R1 reset state
    rd_at(M_USR, 4'd13); chk("R1 user r13", rd_a_data, 32'h0);
    chk("R1 status user", sps_rd_data, 32'h0);
    rd_at(M_FIQ, 4'd10); chk("R1 fiq r10", rd_b_data, 32'h0);
    chk("R1 status fiq", sps_rd_data, 32'h0);

    for (int i = 0; i < NV; i++) begin
      idle();
      mode = TBL[i][40:36];
      rd_a_idx = TBL[i][35:32];
      rd_b_idx = TBL[i][35:32];
      if (!TBL[i][45]) begin
        wr_en = 1'b1; wr_idx = TBL[i][35:32]; wr_data = TBL[i][31:0];
      end else begin
        #1;
        chk($sformatf("R%0d port A entry %0d", TBL[i][44:41], i), rd_a_data, TBL[i][31:0]);
        chk($sformatf("R%0d port B entry %0d", TBL[i][44:41], i), rd_b_data, TBL[i][31:0]);
      end
    end

    // R7 same-cycle forwarding; other port unaffected
    idle();
    mode = M_IRQ; wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'hAAAA;
    rd_a_idx = 4'd13; rd_b_idx = 4'd8;
    #1;
    chk("R7 forward A", rd_a_data, 32'hAAAA);
    chk("R7 port B other", rd_b_data, 32'h0108);
    rd_at(M_IRQ, 4'd13); chk("R7 stored", rd_a_data, 32'hAAAA);

    // R8 override into a mode that is not current
    idle();
    mode = M_USR; lr_ovr_en = 1'b1; lr_ovr_mode = M_SVC; lr_ovr_data = 32'hC0DE;
    rd_at(M_SVC, 4'd14); chk("R8 svc r14", rd_a_data, 32'hC0DE);
    rd_at(M_USR, 4'd14); chk("R8 user r14 kept", rd_a_data, 32'h010E);
    idle();
    lr_ovr_en = 1'b1; lr_ovr_mode = M_SYS; lr_ovr_data = 32'h5151;
    rd_at(M_USR, 4'd14); chk("R8 system target", rd_a_data, 32'h5151);
    idle();
    mode = M_IRQ; wr_en = 1'b1; wr_idx = 4'd14; wr_data = 32'h1111;
    lr_ovr_en = 1'b1; lr_ovr_mode = M_IRQ; lr_ovr_data = 32'h2222;
    rd_a_idx = 4'd14;
    #1;
    chk("R8 collision forward", rd_a_data, 32'h2222);
    rd_at(M_IRQ, 4'd14); chk("R8 collision stored", rd_a_data, 32'h2222);

    // R9 saved-status per exception mode
    idle();
    mode = M_FIQ; sps_wr_en = 1'b1; sps_wr_data = 32'hF1;
    #1;
    chk("R9 status forward", sps_rd_data, 32'hF1);
    idle();
    mode = M_IRQ; sps_wr_en = 1'b1; sps_wr_data = 32'hA2;
    idle();
    mode = M_UND; sps_wr_en = 1'b1; sps_wr_data = 32'hD5;

    // R10 user/system status writes ignored
    idle();
    mode = M_USR; sps_wr_en = 1'b1; sps_wr_data = 32'h99;
    #1;
    chk("R10 user status read", sps_rd_data, 32'h0);
    idle();
    mode = M_SYS; sps_wr_en = 1'b1; sps_wr_data = 32'h98;
    #1;
    chk("R10 system status read", sps_rd_data, 32'h0);

    rd_at(M_FIQ, 4'd0); chk("R9 fiq status", sps_rd_data, 32'hF1);
    rd_at(M_IRQ, 4'd0); chk("R9 irq status", sps_rd_data, 32'hA2);
    rd_at(M_UND, 4'd0); chk("R9 und status", sps_rd_data, 32'hD5);
    rd_at(M_SVC, 4'd0); chk("R10 svc status untouched", sps_rd_data, 32'h0);
    rd_at(M_ABT, 4'd0); chk("R10 abt status untouched", sps_rd_data, 32'h0);
    rd_at(M_USR, 4'd0); chk("R10 user status after", sps_rd_data, 32'h0);

    idle();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements) act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule